// File: doc/BRIEF.md
# Card Memory Window Address Mapper

This block sits between a host memory bus and one card socket. It compares each host memory address against five programmable windows. A window is enabled on its own. It lives in one 16-Mbyte page of host memory, and it covers a 4-Kbyte-granular range inside that page. When a window matches, the block adds that window's offset to the host address to form the card address. It also reports the window number and the access attributes the card sequencer needs: attribute-space select, write suppression and the timing-set index.

The configuration arrives as flat per-window vectors, driven from a register file outside this block. A request is one cycle with `req_vld` high. The decoded result appears on the outputs one clock later and lasts for one cycle.

Top module: `memwin_mapper`

## Requirements
- R1: Each of the five windows has its own enable bit. A window whose enable bit is 0 never produces a hit, whatever address is presented.
- R2: A window matches only when host address bits [31:24] equal that window's 8-bit page field.
- R3: A window matches only when host address bits [23:12] lie between its 12-bit start and end fields. Both bounds are inclusive, so the whole 4-Kbyte block at the end bound belongs to the window.
- R4: On a hit, `card_addr` equals (host address bits [25:0] + (window offset << 12)) modulo 2^26. Any carry out is dropped.
- R5: On a hit, `attr_sel` equals the winning window's attribute-select bit.
- R6: A write that hits a write-protected window sets `wr_block` to 1, while `hit` and `card_addr` are still produced. A read through the same window gives `wr_block` = 0. A window that is not protected never sets `wr_block`.
- R7: On a hit, `tset` equals the winning window's timing-set select bit (0 or 1).
- R8: When several enabled windows match, the lowest-numbered one wins. Its number (0 to 4) appears on `win_idx`.
- R9: Outputs are registered and reflect a request exactly one cycle after `req_vld` is high. In any cycle that follows no request, or a request that matched no window, `hit` is 0 and `win_idx`, `card_addr`, `attr_sel`, `wr_block` and `tset` are all 0.
- R10: After a synchronous active-low reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Address strobe, one cycle per request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host memory address |
| cfg_en | input | 5 | Per-window enable |
| cfg_page | input | 40 | Per-window page, 8 bits each; window i uses bits [8i+7:8i] |
| cfg_start | input | 60 | Per-window start block, 12 bits each |
| cfg_end | input | 60 | Per-window end block, 12 bits each |
| cfg_off | input | 70 | Per-window offset in 4-Kbyte units, 14 bits each |
| cfg_attr | input | 5 | Per-window attribute-space select |
| cfg_wp | input | 5 | Per-window write protect |
| cfg_tset | input | 5 | Per-window timing-set select |
| hit | output | 1 | A window matched the previous request |
| win_idx | output | 3 | Number of the winning window |
| card_addr | output | 26 | Translated card address |
| attr_sel | output | 1 | Access targets attribute space |
| wr_block | output | 1 | Write must be suppressed |
| tset | output | 1 | Timing register set to use |

## Verification
The assertions check on every cycle that a hit always follows a request and that no hit follows a request made while all windows are disabled. They also check that the attribute, suppress and timing outputs stay 0 without a hit, that reads never raise the suppress flag, and that the window number stays in range. Only the bench's scenarios can show the arithmetic content:

- the exact inclusive bound edges, including the last byte of the end block;
- page matching;
- offset wrap past 2^26;
- lowest-index priority among overlapping windows;
- the per-window attribute and timing values.

// File: rtl/memwin_pkg.sv
// Package memwin_pkg
// Purpose: fixed geometry constants shared by the window mapper modules.
// Assumes: windows are confined to 16-Mbyte pages, with 4-Kbyte bound granularity.
package memwin_pkg;
    localparam int PAGE_LSB = 24;   // first address bit of the page field
    localparam int GRAN_LSB = 12;   // first address bit of the bound fields
    localparam int BND_W    = PAGE_LSB - GRAN_LSB;
endpackage

// File: rtl/memwin_cmp.sv
// Module memwin_cmp
// Purpose: decides whether one window matches a host address. The window must be
//          enabled, the page must be equal, and the 4-Kbyte block index must lie
//          within the inclusive start..end bounds.
// Assumes: a start above the end makes an empty window (it never matches).
module memwin_cmp
    import memwin_pkg::*;
#(
    parameter int HA_W = 32
) (
    input  logic                     en,
    input  logic [HA_W-1:0]          addr,
    input  logic [HA_W-PAGE_LSB-1:0] page,
    input  logic [BND_W-1:0]         bnd_lo,
    input  logic [BND_W-1:0]         bnd_hi,
    output logic                     match
);
    logic [BND_W-1:0] blk;

    // Combine the page equality test with the inclusive bound test.
    always_comb begin
        blk   = addr[PAGE_LSB-1:GRAN_LSB];
        match = en
              && (addr[HA_W-1:PAGE_LSB] == page)
              && (blk >= bnd_lo)
              && (blk <= bnd_hi);
    end
endmodule

// File: rtl/memwin_prio.sv
// Module memwin_prio
// Purpose: picks the lowest-numbered set request bit and reports it as a
//          one-hot grant and as a binary index.
// Assumes: IX_W is wide enough to hold N-1.
module memwin_prio #(
    parameter int N    = 5,
    parameter int IX_W = 3
) (
    input  logic [N-1:0]    req,
    output logic [N-1:0]    gnt,
    output logic [IX_W-1:0] idx,
    output logic            any
);
    // Scan from the highest index down, so the lowest set bit is written last and wins.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IX_W'(i);
            end
        end
    end
endmodule

// File: rtl/memwin_xlat.sv
// Module memwin_xlat
// Purpose: selects the winning window's offset and attributes, forms the card
//          address modulo 2^CA_W and computes write suppression.
// Assumes: idx is meaningful only when sel_vld is high; all outputs are 0 otherwise.
module memwin_xlat
    import memwin_pkg::*;
#(
    parameter int N    = 5,
    parameter int IX_W = 3,
    parameter int HA_W = 32,
    parameter int CA_W = 26,
    localparam int OF_W = CA_W - GRAN_LSB
) (
    input  logic              sel_vld,
    input  logic [IX_W-1:0]   idx,
    input  logic [HA_W-1:0]   addr,
    input  logic              wr,
    input  logic [N*OF_W-1:0] offs,
    input  logic [N-1:0]      attrs,
    input  logic [N-1:0]      wps,
    input  logic [N-1:0]      tsets,
    output logic [CA_W-1:0]   card_addr,
    output logic              attr,
    output logic              wblk,
    output logic              ts
);
    logic [OF_W-1:0] off_sel;

    // Select the winning window's offset; the upper bits of the sum drop out by width.
    always_comb begin
        off_sel   = offs[idx*OF_W +: OF_W];
        card_addr = '0;
        attr      = 1'b0;
        wblk      = 1'b0;
        ts        = 1'b0;
        if (sel_vld) begin
            card_addr = addr[CA_W-1:0] + {off_sel, {GRAN_LSB{1'b0}}};
            attr      = attrs[idx];
            wblk      = wr & wps[idx];
            ts        = tsets[idx];
        end
    end
endmodule

// File: rtl/memwin_mapper.sv
// Module memwin_mapper
// Purpose: top of the card memory window mapper. It compares one request
//          against N_WIN windows, resolves priority, translates the address and
//          registers the result one cycle after the strobe.
// Assumes: the configuration is stable around requests; reset is synchronous, active low.
module memwin_mapper
    import memwin_pkg::*;
#(
    parameter int N_WIN = 5,
    parameter int HA_W  = 32,
    parameter int CA_W  = 26,
    localparam int PG_W = HA_W - PAGE_LSB,
    localparam int OF_W = CA_W - GRAN_LSB,
    localparam int IX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_vld,
    input  logic                    req_wr,
    input  logic [HA_W-1:0]         req_addr,
    input  logic [N_WIN-1:0]        cfg_en,
    input  logic [N_WIN*PG_W-1:0]   cfg_page,
    input  logic [N_WIN*BND_W-1:0]  cfg_start,
    input  logic [N_WIN*BND_W-1:0]  cfg_end,
    input  logic [N_WIN*OF_W-1:0]   cfg_off,
    input  logic [N_WIN-1:0]        cfg_attr,
    input  logic [N_WIN-1:0]        cfg_wp,
    input  logic [N_WIN-1:0]        cfg_tset,
    output logic                    hit,
    output logic [IX_W-1:0]         win_idx,
    output logic [CA_W-1:0]         card_addr,
    output logic                    attr_sel,
    output logic                    wr_block,
    output logic                    tset
);
    logic [N_WIN-1:0] match;
    logic [N_WIN-1:0] gnt;
    logic [IX_W-1:0]  idx_c;
    logic             any_c;
    logic [CA_W-1:0]  ca_c;
    logic             attr_c, wblk_c, ts_c;

    // One comparator per window.
    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        memwin_cmp #(.HA_W(HA_W)) i_cmp (
            .en     (cfg_en[w]),
            .addr   (req_addr),
            .page   (cfg_page[w*PG_W +: PG_W]),
            .bnd_lo (cfg_start[w*BND_W +: BND_W]),
            .bnd_hi (cfg_end[w*BND_W +: BND_W]),
            .match  (match[w])
        );
    end

    memwin_prio #(.N(N_WIN), .IX_W(IX_W)) i_prio (
        .req (match),
        .gnt (gnt),
        .idx (idx_c),
        .any (any_c)
    );

    memwin_xlat #(.N(N_WIN), .IX_W(IX_W), .HA_W(HA_W), .CA_W(CA_W)) i_xlat (
        .sel_vld   (any_c),
        .idx       (idx_c),
        .addr      (req_addr),
        .wr        (req_wr),
        .offs      (cfg_off),
        .attrs     (cfg_attr),
        .wps       (cfg_wp),
        .tsets     (cfg_tset),
        .card_addr (ca_c),
        .attr      (attr_c),
        .wblk      (wblk_c),
        .ts        (ts_c)
    );

    // Register the decode; a cycle without a hit leaves every output at 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !(req_vld && any_c)) begin
            hit       <= 1'b0;
            win_idx   <= '0;
            card_addr <= '0;
            attr_sel  <= 1'b0;
            wr_block  <= 1'b0;
            tset      <= 1'b0;
        end else begin
            hit       <= 1'b1;
            win_idx   <= idx_c;
            card_addr <= ca_c;
            attr_sel  <= attr_c;
            wr_block  <= wblk_c;
            tset      <= ts_c;
        end
    end

    // R9
    hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !hit);
    // R1
    all_disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cfg_en == '0) |=> !hit);
    // R6
    read_never_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_wr) |=> !wr_block);
    // R9
    quiet_without_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!attr_sel && !wr_block && !tset && card_addr == '0 && win_idx == '0));
    // R8
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (int'(win_idx) < N_WIN));
    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~match) == '0));
endmodule

// File: tb/test_memwin_mapper.sv
// Bench for memwin_mapper: directed scenarios, one task each, checked against
// a reference model written from the requirements.
module test_memwin_mapper;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_vld = 1'b0;
    logic         req_wr = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [4:0]   cfg_en = '0, cfg_attr = '0, cfg_wp = '0, cfg_tset = '0;
    logic [39:0]  cfg_page = '0;
    logic [59:0]  cfg_start = '0, cfg_end = '0;
    logic [69:0]  cfg_off = '0;
    logic         hit, attr_sel, wr_block, tset;
    logic [2:0]   win_idx;
    logic [25:0]  card_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    memwin_mapper i_memwin_mapper (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
        .cfg_en(cfg_en), .cfg_page(cfg_page), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .cfg_off(cfg_off), .cfg_attr(cfg_attr), .cfg_wp(cfg_wp), .cfg_tset(cfg_tset),
        .hit(hit), .win_idx(win_idx), .card_addr(card_addr), .attr_sel(attr_sel),
        .wr_block(wr_block), .tset(tset)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_win(input int w, input bit en, input logic [7:0] pg,
                           input logic [11:0] lo, input logic [11:0] hi,
                           input logic [13:0] off, input bit at, input bit wp, input bit ts);
        cfg_en[w]             = en;
        cfg_page[w*8 +: 8]    = pg;
        cfg_start[w*12 +: 12] = lo;
        cfg_end[w*12 +: 12]   = hi;
        cfg_off[w*14 +: 14]   = off;
        cfg_attr[w]           = at;
        cfg_wp[w]             = wp;
        cfg_tset[w]           = ts;
    endtask

    // Issue a request at a falling edge; the result is sampled 1 ns after the next rising edge.
    task automatic access(input string req, input logic [31:0] a, input bit wr, input bit strobe);
        int  win;
        bit  eh;
        logic [25:0] eca;
        @(negedge clk);
        req_addr = a; req_wr = wr; req_vld = strobe;
        win = -1;
        for (int i = N - 1; i >= 0; i--)
            if (cfg_en[i] && a[31:24] == cfg_page[i*8 +: 8] &&
                a[23:12] >= cfg_start[i*12 +: 12] && a[23:12] <= cfg_end[i*12 +: 12])
                win = i;
        eh  = strobe && (win >= 0);
        eca = eh ? 26'(a[25:0] + {cfg_off[win*14 +: 14], 12'h000}) : 26'd0;
        @(posedge clk); #1;
        req_vld = 1'b0;
        chk({req, " hit"}, 32'(hit), 32'(eh));
        chk({req, " idx"}, 32'(win_idx), eh ? 32'(win) : 32'd0);
        chk({req, " card_addr"}, 32'(card_addr), 32'(eca));
        chk({req, " attr_sel"}, 32'(attr_sel), eh ? 32'(cfg_attr[win]) : 32'd0);
        chk({req, " wr_block"}, 32'(wr_block), eh ? 32'(wr && cfg_wp[win]) : 32'd0);
        chk({req, " tset"}, 32'(tset), eh ? 32'(cfg_tset[win]) : 32'd0);
    endtask

    task automatic t_reset;
        @(posedge clk); #1;
        chk("R10 reset hit", 32'(hit), 0);
        chk("R10 reset card_addr", 32'(card_addr), 0);
        chk("R10 reset flags", {29'd0, attr_sel, wr_block, tset}, 0);
    endtask

    task automatic t_bounds;
        set_win(0, 1, 8'h12, 12'h010, 12'h01F, 14'h0100, 0, 0, 0);
        access("R3 inside", 32'h1201_5ABC, 0, 1);
        access("R3 start edge", 32'h1201_0000, 0, 1);
        access("R3 end last byte", 32'h1201_FFFF, 0, 1);
        access("R3 below start", 32'h1200_FFFF, 0, 1);
        access("R3 above end", 32'h1202_0000, 0, 1);
    endtask

    task automatic t_page;
        access("R2 wrong page", 32'h1301_5ABC, 0, 1);
        access("R2 right page", 32'h1201_5000, 1, 1);
    endtask

    task automatic t_disable;
        cfg_en[0] = 1'b0;
        access("R1 disabled window", 32'h1201_5ABC, 0, 1);
        cfg_en[0] = 1'b1;
        access("R1 re-enabled window", 32'h1201_5ABC, 0, 1);
    endtask

    task automatic t_priority;
        set_win(1, 1, 8'h40, 12'h100, 12'h2FF, 14'h0001, 0, 0, 0);
        set_win(3, 1, 8'h40, 12'h200, 12'h3FF, 14'h0002, 1, 0, 1);
        access("R8 overlap lowest wins", 32'h4025_0010, 0, 1);
        access("R8 only higher window", 32'h4035_0010, 0, 1);
        cfg_en[1] = 1'b0;
        access("R8 lower disabled", 32'h4025_0010, 0, 1);
        cfg_en[1] = 1'b1;
    endtask

    task automatic t_wrap;
        set_win(2, 1, 8'hFF, 12'hF00, 12'hFFF, 14'h3FFF, 0, 0, 0);
        access("R4 offset wrap", 32'hFFFF_F123, 0, 1);
        access("R4 offset wrap low", 32'hFFF0_0001, 1, 1);
    endtask

    task automatic t_protect;
        set_win(4, 1, 8'h80, 12'h000, 12'h000, 14'h0010, 1, 1, 1);
        access("R6 protected write", 32'h8000_0044, 1, 1);
        access("R6 protected read", 32'h8000_0044, 0, 1);
        cfg_wp[4] = 1'b0;
        access("R6 unprotected write", 32'h8000_0044, 1, 1);
        access("R5 R7 attr and tset", 32'h8000_0FFF, 0, 1);
    endtask

    task automatic t_strobe;
        access("R9 no strobe", 32'h8000_0044, 0, 0);
        access("R9 after idle", 32'h8000_0044, 0, 1);
        @(negedge clk); #0;
        @(posedge clk); #1;
        chk("R9 one cycle pulse", 32'(hit), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_bounds();
        t_page();
        t_disable();
        t_priority();
        t_wrap();
        t_protect();
        t_strobe();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule